// File: doc/BRIEF.md
# Quad-I/O Serial Flash Memory-Mapped Read Bridge

This block makes an external quad-I/O serial NOR flash appear as read-only memory on a simple internal request/response bus. A read whose address falls inside a fixed 256 MB window turns into one complete serial transaction. The transaction sends the fast-read opcode, then a 32-bit flash address and a configurable number of turnaround (dummy) cycles. It then collects four data bytes and returns them as one 32-bit word. All phases use the four data lines.

Three configuration inputs set the transaction. The first is the flash size, given as an exponent. The second is the dummy cycle count. The third is the serial clock divider. The bridge latches all three when it accepts a request. Reads beyond the programmed flash size, reads outside the window and any write receive an error response, and the serial pins stay idle for them. Bytes are assembled little-endian and need not be word aligned, so a word read at any byte offset returns the four bytes that start there.

Top module: `sflash_rd_bridge`

## Requirements
- R1: A read is decoded only when address bits [31:28] equal 4'h9. Any request outside this window gets an error response one cycle after acceptance, and chip select stays high.
- R2: With size exponent E, the offset (address bits [27:0]) must be below 2^(E+1). Otherwise the read gets an error response with no serial activity. An E of 27 or more opens the whole 256 MB window.
- R3: A write request anywhere completes with an error response and zero data. It never lowers chip select.
- R4: Each transaction drives dq_o with dq_oe_o high for 10 serial cycles. These cycles carry opcode 8'hEC as two nibbles, then the 32-bit flash address (the offset zero-extended) as eight nibbles, all most-significant nibble first.
- R5: After the address, the bridge inserts exactly D dummy serial cycles (D = dummy input), with dq_oe_o low. Eight data nibbles follow with dq_oe_o low.
- R6: The serial clock idles low and has a period of max(V,1)+1 system clock cycles, where V is the divider input. The bridge changes dq_o only while the serial clock is low and samples dq_i at each rising serial clock edge.
- R7: The first byte received goes to rsp_data_o[7:0] and the fourth to [31:24]. Each byte arrives high nibble first. A read at offset A returns flash bytes A..A+3.
- R8: rsp_valid_o is a one-cycle pulse. For a good read it comes only after all eight data nibbles have been sampled, in the cycle after chip select rises. req_ready_o is low while chip select is low.
- R9: Between two transactions, chip select stays high for at least one serial clock period.
- R10: After reset, chip select is high, the serial clock is low, req_ready_o is high and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when high with valid |
| req_write_i | input | 1 | Request is a write (always refused) |
| req_addr_i | input | 32 | Byte address of the request |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Response is an error |
| rsp_data_o | output | 32 | Read data, little-endian |
| cfg_size_exp_i | input | 5 | Flash size exponent E (2^(E+1) bytes) |
| cfg_dummy_i | input | 5 | Dummy serial cycles between address and data |
| cfg_div_i | input | 8 | Serial clock divider V |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| dq_o | output | 4 | Serial data out |
| dq_oe_o | output | 4 | Output enable per data line |
| dq_i | input | 4 | Serial data in |

## Verification
The bench models the flash behaviourally from the serial pins. The model records the opcode and address, and it serves bytes from a computed memory image. Directed reads at offsets 0, 1, 2, 4 and 8 separate correct little-endian assembly from byte-swapped or misaligned assembly and from wrong dummy counting. Changing the dummy count (0, 6, 10) and the divider (0, 2, 3, 4) also shows whether the bridge counts the turnaround or the clock period wrongly. Boundary reads at 2^(E+1)-4 and 2^(E+1), and reads just outside the window, test the decode limits. Writes test that refused requests stay silent on the pins. Seeded random mixes of size exponent, dummy count, divider, offset and request kind then cover combinations the directed cases miss.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [3:0] WIN_TAG   = 4'h9;
  localparam int         OFS_W     = 28;
  localparam logic [7:0] RD_OPCODE = 8'hEC;
  localparam int         NIB_CMD   = 2;
  localparam int         NIB_ADR   = 8;
  localparam int         NIB_DAT   = 8;
  localparam int         NIB_HDR   = NIB_CMD + NIB_ADR;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
  import sfr_pkg::*;
#(
  parameter int EXP_W = 5
) (
  input  logic [31:0]      addr_i,
  input  logic             write_i,
  input  logic [EXP_W-1:0] size_exp_i,
  output logic             go_o,
  output logic [OFS_W-1:0] ofs_o
);
  localparam int TAG_W = 32 - OFS_W;

  logic [EXP_W:0] lim_bits;
  logic [31:0]    ofs_ext;
  logic           in_win;
  logic           in_rng;

  always_comb begin
    lim_bits = {1'b0, size_exp_i} + {{EXP_W{1'b0}}, 1'b1};
    ofs_ext  = {{TAG_W{1'b0}}, addr_i[OFS_W-1:0]};
    in_win   = (addr_i[31:OFS_W] == WIN_TAG);
    in_rng   = ((ofs_ext >> lim_bits) == 32'd0);
    go_o     = in_win && in_rng && !write_i;
    ofs_o    = addr_i[OFS_W-1:0];
  end
endmodule

// File: rtl/sfr_sckgen.sv
module sfr_sckgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic [DIV_W:0]   per;
  logic [DIV_W:0]   lo_last;
  logic             tick_en;

  always_comb begin
    per     = {1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1};
    lo_last = per - (per >> 1) - {{DIV_W{1'b0}}, 1'b1};
    rise_o  = run_i && ({1'b0, cnt_q} == lo_last);
    fall_o  = run_i && (cnt_q == div_i);
    tick_en = run_i || sck_q || (cnt_q != '0);
    if (!run_i) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else begin
      cnt_d = fall_o ? '0 : cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
      sck_d = rise_o ? 1'b1 : (fall_o ? 1'b0 : sck_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o = sck_q;

  // R6: the serial clock rests low whenever no transaction runs
  p_sck_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_i && !$past(run_i)) |-> !sck_o);
endmodule

// File: rtl/sfr_engine.sv
module sfr_engine
  import sfr_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DUM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             go_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [DUM_W-1:0] cfg_dummy_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [3:0]       dq_i,
  output logic             req_ready_o,
  output logic             run_o,
  output logic [DIV_W-1:0] div_o,
  output logic             cs_n_o,
  output logic [3:0]       dq_o,
  output logic [3:0]       dq_oe_o,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [31:0]      rsp_data_o
);
  localparam int SEQ_MAX = NIB_HDR + NIB_DAT - 1 + (1 << DUM_W) - 1;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);
  localparam int FRM_W   = 8 + 32;

  seq_st_e          st_q, st_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [DUM_W-1:0] dum_q, dum_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] gap_q, gap_d;
  logic [31:0]      dat_q, dat_d;
  logic             rv_q, rv_d, re_q, re_d;
  logic [31:0]      rd_q, rd_d;

  logic             accept;
  logic [SEQ_W-1:0] dstart, slast;
  logic             in_hdr, in_dat;
  logic [2:0]       jn;
  logic [4:0]       pos;
  logic [FRM_W-1:0] frame;
  logic [5:0]       nib_lsb;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    req_ready_o = (st_q == ST_IDLE);
    accept      = req_valid_i && req_ready_o;
    run_o       = (st_q == ST_SHIFT);
    cs_n_o      = !run_o;
    dstart      = SEQ_W'(NIB_HDR) + SEQ_W'(dum_q);
    slast       = dstart + SEQ_W'(NIB_DAT - 1);
    in_hdr      = run_o && (seq_q < SEQ_W'(NIB_HDR));
    in_dat      = run_o && (seq_q >= dstart);
    jn          = 3'(seq_q - dstart);
    pos         = {jn[2:1], ~jn[0], 2'b00};
    frame       = {RD_OPCODE, {(32-OFS_W){1'b0}}, ofs_q};
    nib_lsb     = 6'(4 * (NIB_HDR - 1) - 4 * int'(seq_q));
    dq_o        = in_hdr ? frame[nib_lsb +: 4] : 4'h0;
    dq_oe_o     = {4{in_hdr}};
    div_o       = div_q;
    div_eff     = (cfg_div_i == '0) ? DIV_W'(1) : cfg_div_i;
  end

  always_comb begin
    st_d  = st_q;
    seq_d = seq_q;
    ofs_d = ofs_q;
    dum_d = dum_q;
    div_d = div_q;
    gap_d = gap_q;
    dat_d = dat_q;
    rv_d  = 1'b0;
    re_d  = re_q;
    rd_d  = rd_q;
    if (in_dat && rise_i) dat_d[pos +: 4] = dq_i;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (go_i) begin
            st_d  = ST_SHIFT;
            seq_d = '0;
            ofs_d = ofs_i;
            dum_d = cfg_dummy_i;
            div_d = div_eff;
          end else begin
            rv_d = 1'b1;
            re_d = 1'b1;
            rd_d = 32'd0;
          end
        end
      end
      ST_SHIFT: begin
        if (fall_i) begin
          if (seq_q == slast) begin
            st_d  = ST_GAP;
            gap_d = div_q;
            rv_d  = 1'b1;
            re_d  = 1'b0;
            rd_d  = dat_q;
          end else begin
            seq_d = seq_q + {{(SEQ_W-1){1'b0}}, 1'b1};
          end
        end
      end
      ST_GAP: begin
        if (gap_q == '0) st_d = ST_IDLE;
        else             gap_d = gap_q - {{(DIV_W-1){1'b0}}, 1'b1};
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      seq_q <= '0;
      ofs_q <= '0;
      dum_q <= '0;
      div_q <= DIV_W'(1);
      gap_q <= '0;
      dat_q <= '0;
      rv_q  <= 1'b0;
      re_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      if (accept) begin
        ofs_q <= ofs_d;
        dum_q <= dum_d;
        div_q <= div_d;
      end
      if (run_o || accept) seq_q <= seq_d;
      if (st_q != ST_IDLE) gap_q <= gap_d;
      if (in_dat && rise_i) dat_q <= dat_d;
      if (rv_d) begin
        re_q <= re_d;
        rd_q <= rd_d;
      end
    end
  end

  assign rsp_valid_o = rv_q;
  assign rsp_err_o   = re_q;
  assign rsp_data_o  = rd_q;

  // R3: a write is refused and leaves chip select high
  p_wr_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (accept && req_write_i) |=> (cs_n_o && rsp_valid_o && rsp_err_o));
  // R1: an error response never comes with serial activity
  p_err_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rsp_valid_o && rsp_err_o) |-> (cs_n_o && $past(cs_n_o)));
  // R8: good data is returned only right after a completed transaction
  p_rsp_after_xfer_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rsp_valid_o && !rsp_err_o) |-> !$past(cs_n_o));
  // R9: chip select stays high for more than the edge on which it rises
  p_cs_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(cs_n_o) |=> cs_n_o);
  // R8: no request is taken while a transaction is active
  p_busy_no_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cs_n_o |-> !req_ready_o);
endmodule

// File: rtl/sflash_rd_bridge.sv
module sflash_rd_bridge
  import sfr_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int DUM_W = 5,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [31:0]      req_addr_i,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [31:0]      rsp_data_o,
  input  logic [EXP_W-1:0] cfg_size_exp_i,
  input  logic [DUM_W-1:0] cfg_dummy_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic [3:0]       dq_o,
  output logic [3:0]       dq_oe_o,
  input  logic [3:0]       dq_i
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             go;
  logic [OFS_W-1:0] ofs;
  logic             run;
  logic [DIV_W-1:0] div_lat;
  logic             rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sfr_decode #(.EXP_W(EXP_W)) u_decode (
    .addr_i     (req_addr_i),
    .write_i    (req_write_i),
    .size_exp_i (cfg_size_exp_i),
    .go_o       (go),
    .ofs_o      (ofs)
  );

  sfr_sckgen #(.DIV_W(DIV_W)) u_sckgen (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .run_i  (run),
    .div_i  (div_lat),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sfr_engine #(.DIV_W(DIV_W), .DUM_W(DUM_W)) u_engine (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .go_i        (go),
    .ofs_i       (ofs),
    .cfg_dummy_i (cfg_dummy_i),
    .cfg_div_i   (cfg_div_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .dq_i        (dq_i),
    .req_ready_o (req_ready_o),
    .run_o       (run),
    .div_o       (div_lat),
    .cs_n_o      (cs_n_o),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_data_o  (rsp_data_o)
  );
endmodule

// File: tb/sflash_rd_bridge_bench.sv
module sflash_rd_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic [4:0]  cfg_exp = 5'd25, cfg_dum = 5'd6;
  logic [7:0]  cfg_div = 8'd2;
  logic        sck, cs_n;
  logic [3:0]  dq_o, dq_oe, dq_i = 4'h0;

  int checks = 0, errors = 0, cyc = 0;
  int cur_dummy = 6, cur_p = 3, last_p = 3;

  always #4 clk = ~clk;

  sflash_rd_bridge u_sflash_rd_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .rsp_valid_o(rsp_valid),
    .rsp_err_o(rsp_err), .rsp_data_o(rsp_data), .cfg_size_exp_i(cfg_exp),
    .cfg_dummy_i(cfg_dum), .cfg_div_i(cfg_div), .sck_o(sck), .cs_n_o(cs_n),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i));

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    case (a)
      32'd0: return 8'h67; 32'd1: return 8'h45; 32'd2: return 8'h23; 32'd3: return 8'h01;
      32'd4: return 8'hEF; 32'd5: return 8'hCD; 32'd6: return 8'hAB; 32'd7: return 8'h89;
      default: return (a < 32'h1000) ? 8'hFF : (a[7:0] ^ a[15:8] ^ a[23:16] ^ {4'h0, a[27:24]} ^ 8'h5A);
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] o);
    return {fbyte(o + 3), fbyte(o + 2), fbyte(o + 1), fbyte(o)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  // flash model, driven only from the serial pins
  int c_rise = 0, oe_bad = 0, dnib = 0;
  logic [7:0]  cmd_cap = '0;
  logic [31:0] adr_cap = '0;
  always @(negedge cs_n) begin
    c_rise = 0; cmd_cap = '0; adr_cap = '0; dnib = 0;
  end
  always @(posedge sck) begin
    if (!cs_n) begin
      if (c_rise < 2) begin
        cmd_cap = {cmd_cap[3:0], dq_o};
        if (dq_oe != 4'hF) oe_bad++;
      end else if (c_rise < 10) begin
        adr_cap = {adr_cap[27:0], dq_o};
        if (dq_oe != 4'hF) oe_bad++;
      end else if (dq_oe != 4'h0) oe_bad++;
      c_rise++;
    end
  end
  always @(negedge sck) begin : mdl_drv
    int j;
    logic [7:0] b;
    if (!cs_n) begin
      j = c_rise - 10 - cur_dummy;
      if (j >= 0 && j < 8) begin
        b = fbyte(adr_cap + 32'(j / 2));
        dq_i = (j % 2 == 0) ? b[7:4] : b[3:0];
        dnib++;
      end
    end
  end

  // pin monitor on the inactive clock edge
  int per_bad = 0, gap_bad = 0, rdy_bad = 0, cs_falls = 0;
  int rcnt = 0, hcnt = 0;
  bit have_rise = 0, seen_xfer = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      rcnt++;
      if (sck && !prev_sck) begin
        if (have_rise && rcnt != cur_p) per_bad++;
        have_rise = 1; rcnt = 0;
      end
      if (cs_n) begin
        have_rise = 0;
        hcnt++;
      end
      if (!cs_n && prev_cs) begin
        cs_falls++;
        if (seen_xfer && hcnt < last_p) gap_bad++;
        seen_xfer = 1;
      end
      if (cs_n && !prev_cs) begin
        last_p = cur_p; hcnt = 1;
      end
      if (!cs_n && req_ready) rdy_bad++;
    end
    prev_sck = sck; prev_cs = cs_n;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 200000) begin
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected under 200000", cyc);
    finish_run();
  end

  task automatic setcfg(input int e, input int d, input int v);
    @(negedge clk);
    cfg_exp = 5'(e); cfg_dum = 5'(d); cfg_div = 8'(v);
    cur_dummy = d; cur_p = ((v == 0) ? 1 : v) + 1;
  endtask

  task automatic issue(input bit wr, input logic [31:0] a, output logic [31:0] d, output logic e);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
    d = rsp_data; e = rsp_err;
  endtask

  task automatic rd_ok(input logic [31:0] a, input string tag);
    logic [31:0] d, ofs, expv;
    logic e;
    int ob = oe_bad, pb = per_bad;
    ofs = {4'h0, a[27:0]};
    expv = exp_word(ofs);
    issue(1'b0, a, d, e);
    chk(!e && rsp_valid, {tag, " R1 R2 read accepted"}, {31'd0, e}, 32'd0);
    chk(d == expv, {tag, " R7 data"}, d, expv);
    chk(cmd_cap == 8'hEC && adr_cap == ofs, {tag, " R4 address"}, adr_cap, ofs);
    chk(oe_bad == ob, {tag, " R4 R5 output enable"}, 32'(oe_bad - ob), 32'd0);
    chk(dnib == 8 && cs_n, {tag, " R8 response after data"}, 32'(dnib), 32'd8);
    chk(per_bad == pb, {tag, " R6 serial clock period"}, 32'(per_bad - pb), 32'd0);
  endtask

  task automatic rd_err(input bit wr, input logic [31:0] a, input string tag);
    logic [31:0] d;
    logic e;
    int f = cs_falls;
    issue(wr, a, d, e);
    chk(e && rsp_valid && d == 32'd0, {tag, " error response"}, d, 32'd0);
    chk(cs_falls == f, {tag, " no serial activity"}, 32'(cs_falls - f), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R10 chip select after reset", {31'd0, cs_n}, 32'd1);
    chk(sck == 1'b0, "R10 serial clock after reset", {31'd0, sck}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R10 no response after reset", {31'd0, rsp_valid}, 32'd0);

    setcfg(25, 6, 2);
    rd_ok(32'h9000_0000, "offset 0");
    rd_ok(32'h9000_0002, "offset 2 unaligned");
    rd_ok(32'h9000_0008, "offset 8 erased");
    setcfg(25, 0, 2);
    rd_ok(32'h9000_0004, "R5 dummy 0");
    setcfg(25, 10, 3);
    rd_ok(32'h9000_0001, "R5 dummy 10");
    setcfg(25, 6, 0);
    rd_ok(32'h9001_2345, "R6 divider 0");
    setcfg(25, 6, 4);
    rd_ok(32'h9012_3456, "R6 divider 4");
    rd_err(1'b1, 32'h9000_0000, "R3 write");
    rd_err(1'b1, 32'h1234_5678, "R3 write outside");
    rd_err(1'b0, 32'h9400_0000, "R2 at size limit");
    rd_ok(32'h93FF_FFFC, "R2 last word");
    rd_err(1'b0, 32'h8FFF_FFFC, "R1 below window");
    rd_err(1'b0, 32'hA000_0000, "R1 above window");
    setcfg(27, 6, 1);
    rd_ok(32'h9FFF_FFFC, "R2 full window");

    for (int i = 0; i < 24; i++) begin
      int e = 11 + int'($urandom % 17);
      int k = int'($urandom % 4);
      logic [31:0] lim = 32'd1 << (e + 1);
      logic [31:0] o = $urandom & (lim - 1) & 32'h0FFF_FFFF;
      setcfg(e, int'($urandom % 13), int'($urandom % 5));
      if (k == 0) rd_err(1'b1, {4'h9, o[27:0]}, "R3 random write");
      else if (k == 1 && e < 27) rd_err(1'b0, {4'h9, 28'(lim + (o & 32'hFF))}, "R2 random beyond");
      else rd_ok({4'h9, o[27:0]}, "random read");
    end

    repeat (10) @(negedge clk);
    chk(gap_bad == 0, "R9 chip select gap", 32'(gap_bad), 32'd0);
    chk(rdy_bad == 0, "R8 ready low while busy", 32'(rdy_bad), 32'd0);
    chk(per_bad == 0, "R6 all serial periods", 32'(per_bad), 32'd0);
    finish_run();
  end
endmodule